// File: doc/BRIEF.md
# Audio Master Clock Ratio Generator

This block produces the audio master clock for a codec by dividing a fast reference clock by a power of two. The reference clock `clk_i` runs at twice the audio port clock. The port clock is 512·fs when the family select is 0 and 384·fs when it is 1. Running the reference at twice that rate lets a registered output give the full port-clock ratio. A 3-bit divide code n gives an output period of 2^(n+1) reference cycles. That period is port/2^n, with a 50 % duty cycle.

The family select does not change the divider. It changes which codes are legal, and so which ratios a code reaches. In the 512 family, codes 0 to 4 give 512, 256, 128, 64 and 32 times fs. In the 384 family, codes 0 to 3 give 384, 192, 96 and 48 times fs. The output runs while the run input is high and the gate input is low. Every start, stop and configuration change is aligned to a rising edge of the output, so no shortened pulse ever appears. An illegal setting raises an error flag and keeps the output low.

Top module: `mclk_ratio_gen`

## Requirements
- R1: While `rst_ni` is low, `mclk_o` and `cfg_err_o` are 0.
- R2: With `base_sel_i`=0 and a stable legal code n in 0..4, `mclk_o` is periodic with a period of 2^(n+1) `clk_i` cycles.
- R3: With `base_sel_i`=1 and a stable legal code n in 0..3, `mclk_o` is periodic with a period of 2^(n+1) `clk_i` cycles.
- R4: Every high pulse and every low gap of a running `mclk_o` lasts exactly 2^n cycles, where n is the code taken at that pulse's rising edge.
- R5: Code 4 with `base_sel_i`=1, and codes 5, 6 and 7 with either select, are illegal. An illegal code raises `cfg_err_o` and never starts `mclk_o`. A rising edge that would take an illegal code is not produced, and the output stays low.
- R6: When `run_i` is 0 or `gate_i` is 1, the pulse in progress completes at full length and `mclk_o` then stays low. When running is allowed and the code is legal, the first high cycle of `mclk_o` follows one clock edge after an idle output sees the enable.
- R7: A code change while running takes effect only at the next rising edge of `mclk_o`. The current high pulse and low gap keep the old length.
- R8: `cfg_err_o` shows the legality of the `base_sel_i`/`mult_i` value sampled at the previous clock edge, whatever `run_i` and `gate_i` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, twice the audio port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_sel_i | input | 1 | Family select: 0 = 512·fs port clock, 1 = 384·fs port clock |
| mult_i | input | 3 | Divide code n; output = port clock / 2^n |
| run_i | input | 1 | Enables the output |
| gate_i | input | 1 | Gates the output off when high |
| mclk_o | output | 1 | Audio master clock |
| cfg_err_o | output | 1 | Illegal family/code combination |

## Verification
The output is a pure function of a small counter and a held code. A corrupted count or held code therefore shows up as a pulse of the wrong length within one output period, at most 32 reference cycles. The bench compares the output with a behavioural model on every cycle, so such a deviation is flagged in the cycle it occurs. A stop or code change that is not aligned to a rising edge shows up as a short pulse or gap on the very next transition. A wrong legality decision shows on the error flag one cycle after the input changes.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  localparam int CODE_W  = 3;
  localparam int MAX_B0  = 4;
  localparam int MAX_B1  = 3;

  function automatic logic code_legal(input logic base, input logic [CODE_W-1:0] code,
                                      input int max0, input int max1);
    int lim;
    lim = base ? max1 : max0;
    return (int'(code) <= lim);
  endfunction
endpackage

// File: rtl/mclk_cfg_chk.sv
module mclk_cfg_chk #(
  parameter int CODE_W = 3,
  parameter int MAX0   = 4,
  parameter int MAX1   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              legal_o,
  output logic              err_o
);
  assign legal_o = mclk_pkg::code_legal(base_i, code_i, MAX0, MAX1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= ~legal_o;
  end
endmodule

// File: rtl/mclk_half_cnt.sv
module mclk_half_cnt #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tc_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim  = CNT_W'((32'd1 << code_i) - 32'd1);
  assign tc_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else if (tc_o)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mclk_phase_fsm.sv
module mclk_phase_fsm #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              tc_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              mclk_o,
  output logic              busy_o,
  output logic [CODE_W-1:0] code_o
);
  logic              mclk_q, busy_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mclk_q <= 1'b0;
      busy_q <= 1'b0;
      code_q <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        mclk_q <= 1'b1;
        code_q <= code_i;
      end
    end else if (tc_i) begin
      if (mclk_q) begin
        mclk_q <= 1'b0;
      end else if (go_i) begin
        // rising edge: only point where a new code is taken
        mclk_q <= 1'b1;
        code_q <= code_i;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign mclk_o = mclk_q;
  assign busy_o = busy_q;
  assign code_o = code_q;
endmodule

// File: rtl/mclk_ratio_gen.sv
module mclk_ratio_gen #(
  parameter int CODE_W = mclk_pkg::CODE_W,
  parameter int MAX0   = mclk_pkg::MAX_B0,
  parameter int MAX1   = mclk_pkg::MAX_B1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_sel_i,
  input  logic [CODE_W-1:0] mult_i,
  input  logic              run_i,
  input  logic              gate_i,
  output logic              mclk_o,
  output logic              cfg_err_o
);
  localparam int MAXC  = (MAX0 > MAX1) ? MAX0 : MAX1;
  localparam int CNT_W = (MAXC > 0) ? MAXC : 1;

  logic              legal, go, tc, busy;
  logic [CODE_W-1:0] act_code;

  mclk_cfg_chk #(.CODE_W(CODE_W), .MAX0(MAX0), .MAX1(MAX1)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_i(base_sel_i), .code_i(mult_i),
    .legal_o(legal), .err_o(cfg_err_o)
  );

  assign go = run_i & ~gate_i & legal;

  mclk_half_cnt #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(busy), .code_i(act_code), .tc_o(tc)
  );

  mclk_phase_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .tc_i(tc), .code_i(mult_i),
    .mclk_o(mclk_o), .busy_o(busy), .code_o(act_code)
  );
endmodule

// File: rtl/mclk_ratio_gen_sva.sv
module mclk_ratio_gen_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       base_sel_i,
  input logic [2:0] mult_i,
  input logic       run_i,
  input logic       gate_i,
  input logic       mclk_o,
  input logic       cfg_err_o
);
  logic       illegal;
  logic       mclk_d, seen;
  logic [2:0] mult_d, hcode;
  logic [5:0] hi_cnt;

  assign illegal = (mult_i > 3'd4) || (base_sel_i && mult_i == 3'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mclk_d <= 1'b0; seen <= 1'b0; mult_d <= '0; hcode <= '0; hi_cnt <= '0;
    end else begin
      mclk_d <= mclk_o;
      mult_d <= mult_i;
      hi_cnt <= mclk_o ? hi_cnt + 6'd1 : 6'd0;
      if (mclk_o && !mclk_d) begin
        hcode <= mult_d;
        seen  <= 1'b1;
      end
    end
  end

  assert_err_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal |=> cfg_err_o);
  assert_err_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !illegal |=> !cfg_err_o);
  assert_illegal_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mclk_o && illegal) |=> !mclk_o);
  assert_run_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mclk_o && (!run_i || gate_i)) |=> !mclk_o);
  assert_pulse_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && mclk_d && !mclk_o) |-> (hi_cnt == (6'd1 << hcode)));
  assert_reset_low_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!mclk_o && !cfg_err_o));
endmodule

bind mclk_ratio_gen mclk_ratio_gen_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .base_sel_i(base_sel_i), .mult_i(mult_i),
  .run_i(run_i), .gate_i(gate_i), .mclk_o(mclk_o), .cfg_err_o(cfg_err_o)
);

// File: tb/sim_mclk_ratio_gen.sv
`timescale 1ns/1ps
module sim_mclk_ratio_gen;
  logic       clk = 0, rst_n = 0;
  logic       base = 0, run = 0, gate = 0;
  logic [2:0] mult = 0;
  logic       mclk, err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mclk_ratio_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .base_sel_i(base), .mult_i(mult),
    .run_i(run), .gate_i(gate), .mclk_o(mclk), .cfg_err_o(err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit legal(input bit b, input int m);
    return b ? (m <= 3) : (m <= 4);
  endfunction

  // behavioural reference: remaining cycles of the current phase
  bit m_busy, m_mclk, m_err;
  int m_left, m_code;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_mclk = 0; m_err = 0; m_left = 0; m_code = 0;
    end else begin
      bit g;
      g = run && !gate && legal(base, int'(mult));
      m_err = !legal(base, int'(mult));
      if (!m_busy) begin
        if (g) begin m_busy = 1; m_mclk = 1; m_code = mult; m_left = 1 << mult; end
      end else begin
        m_left--;
        if (m_left == 0) begin
          if (m_mclk) begin m_mclk = 0; m_left = 1 << m_code; end
          else if (g) begin m_mclk = 1; m_code = mult; m_left = 1 << mult; end
          else m_busy = 0;
        end
      end
      #5;
      if (!done) begin
        check(mclk == m_mclk, "model mclk R2 R3 R6 R7", mclk, m_mclk);
        check(err == m_err, "model err R5 R8", err, m_err);
      end
    end
  end

  task automatic meas(output int per, output int hi);
    bit prev;
    prev = mclk;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (mclk && !prev) break;
      prev = mclk;
    end
    per = 0; hi = 1; prev = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      per++;
      if (mclk && !prev) break;
      if (mclk) hi++;
      prev = mclk;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int per, hi;
    repeat (3) @(negedge clk);
    check(mclk == 0 && err == 0, "reset R1", {mclk, err}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int b = 0; b < 2; b++) begin
      for (int n = 0; n <= (b ? 3 : 4); n++) begin
        base = b[0]; mult = 3'(n); run = 1;
        meas(per, hi); meas(per, hi);
        check(per == (2 << n), b ? "period R3" : "period R2", per, 2 << n);
        check(hi == (1 << n), "duty R4", hi, 1 << n);
      end
    end

    // R7: code change mid pulse keeps the old pulse length
    base = 0; mult = 3; run = 1;
    meas(per, hi);
    @(negedge clk); mult = 0;
    hi = 2;
    for (int i = 0; i < 40 && mclk; i++) begin @(negedge clk); if (mclk) hi++; end
    check(hi == 8, "old pulse kept R7", hi, 8);
    meas(per, hi);
    check(per == 2, "new code applied R7", per, 2);

    // R6: stop mid pulse completes the pulse then stays low
    mult = 3;
    meas(per, hi); meas(per, hi);
    @(negedge clk); run = 0;
    hi = 2;
    for (int i = 0; i < 40 && mclk; i++) begin @(negedge clk); if (mclk) hi++; end
    check(hi == 8, "full pulse on stop R6", hi, 8);
    hi = 0;
    repeat (40) begin @(negedge clk); if (mclk) hi++; end
    check(hi == 0, "stays low after stop R6", hi, 0);

    // R6: gate stops, restart from idle
    run = 1; gate = 1;
    repeat (10) @(negedge clk);
    check(mclk == 0, "gate holds low R6", mclk, 0);
    gate = 0; mult = 1;
    @(negedge clk);
    check(mclk == 1, "start one edge after enable R6", mclk, 1);

    // R5: illegal codes hold output low
    run = 0;
    repeat (20) @(negedge clk);
    base = 1; mult = 4; run = 1;
    @(negedge clk);
    check(err == 1, "illegal 384 code4 R5", err, 1);
    hi = 0;
    repeat (20) begin @(negedge clk); if (mclk) hi++; end
    check(hi == 0, "illegal no start R5", hi, 0);
    base = 0; mult = 7;
    @(negedge clk);
    check(err == 1 && mclk == 0, "illegal code7 R5", {err, mclk}, 2);
    mult = 4;
    @(negedge clk);
    check(err == 0, "code4 legal in 512 R8", err, 0);

    // R8: flag independent of run
    run = 0; base = 0; mult = 6;
    @(negedge clk);
    check(err == 1, "err with run low R8", err, 1);
    mult = 2;
    @(negedge clk);
    check(err == 0, "err clears R8", err, 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule